// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous byte-wide static RAM. The RAM has 2^17 locations. The host presents one request at a time: a write flag, an address and write data, qualified by a request line. The block accepts the request only in a cycle where it reports itself ready. It then drives the RAM's address, its two chip selects (one active-low, one active-high), its output enable and its write enable. For writes it also drives the data bus, through a separate tri-state enable.

Every strobe window is a whole number of clock cycles. Each count is derived when the block is elaborated, from nanosecond timing parameters and the clock period. The quotient is rounded up, and no count is smaller than one cycle. A read keeps output enable low for the full access window and samples the RAM on the last edge of that window. The block then waits for the RAM's outputs to float before it reports ready again. A write holds write enable low for the longest of the pulse, select-to-end, address-to-end and data-to-end windows. The data stays on the bus for one extra cycle after write enable rises. The chip is then deselected for the rest of the write cycle. Whenever the block is idle, it deselects the chip and keeps both enables high.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `host_ready` is high (idle, and directly after reset), `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: A request is taken only at a rising edge where both `host_req` and `host_ready` are high. A request raised and dropped while `host_ready` is low causes no transaction, and no write happens at its address.
- R3: A read (`host_we`=0) keeps the chip selected (`mem_cs_n`=0, `mem_cs`=1) and `mem_oe_n` low for N_RD cycles, with the address held stable. N_RD is the largest of ceil(t/period) over the read cycle, address access, select access and enable access times. `mem_dq_in` is sampled into `host_rdata` on the last edge of that window.
- R4: `host_rdata` changes only when a read completes. It holds its value through idle cycles and through writes.
- R5: After a read window, `host_ready` stays low for N_HZ further cycles with the chip deselected. N_HZ is ceil of the larger output-float time. `mem_dq_oe` never rises while the RAM may still drive the bus.
- R6: A write (`host_we`=1) holds `mem_we_n` low for exactly N_WP cycles, with `mem_oe_n` high and the chip selected. N_WP is the largest of ceil(t/period) over the pulse width, select-to-end, address-to-end and data-to-end times.
- R7: `mem_dq_oe` is high only while `mem_we_n` is low and during the one cycle right after it rises. In that cycle the chip is still selected and `mem_dq_out` still holds the write data.
- R8: From acceptance to the return of `host_ready`, a write takes N_WP + 1 + N_TAIL cycles. N_TAIL is the larger of 1 and N_WC − N_WP − 1, where N_WC is ceil of the write cycle time.
- R9: A request presented while `host_ready` is high is accepted at the next edge, so `host_ready` is low in the following cycle. Back-to-back requests lose no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request valid |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Request address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Idle; a request is accepted at the next edge |
| host_rdata | output | DATA_W | Data from the last completed read |
| mem_addr | output | ADDR_W | RAM address bus |
| mem_dq_out | output | DATA_W | Data driven toward the RAM |
| mem_dq_in | input | DATA_W | Data returned by the RAM |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_out` |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
Two events can fall in the same cycle. The first cycle in which ready returns after a read can also be the cycle in which the next request, often a write, is taken. That write then starts to drive the bus right after the RAM's float window. The bench provokes this by presenting every next request on the same clock phase in which it first sees ready high, across a full sweep of writes and reads over a small address space. Its RAM model keeps driving the bus for the float time after each read and flags any cycle in which the controller's drive enable overlaps that. It also checks that ready fell at once and that the data just captured survives the following write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD,
      PH_RD_FLOAT,
      PH_WR,
      PH_WR_HOLD,
      PH_WR_TAIL
   } phase_e;

   // Whole clock cycles covering a time in ns, never fewer than one.
   function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                input int unsigned period_ns);
      int unsigned c;
      c = (t_ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // Window length accuracy behind R3/R6: an unloaded running count steps down by one.
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4,
   parameter int N_RD   = 7,
   parameter int N_HZ   = 3,
   parameter int N_WP   = 6,
   parameter int N_TAIL = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tmr_done,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output phase_e            phase,
   output logic              ready,
   output logic              capture,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);
   phase_e phase_q, phase_d;
   logic   accept;

   always_comb begin
      phase_d  = phase_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      unique case (phase_q)
         PH_IDLE: if (req) begin
            accept   = 1'b1;
            tmr_load = 1'b1;
            if (we) begin
               phase_d = PH_WR;
               tmr_val = CNT_W'(N_WP - 1);
            end else begin
               phase_d = PH_RD;
               tmr_val = CNT_W'(N_RD - 1);
            end
         end
         PH_RD: if (tmr_done) begin
            capture  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(N_HZ - 1);
            phase_d  = PH_RD_FLOAT;
         end
         PH_RD_FLOAT: if (tmr_done) phase_d = PH_IDLE;
         PH_WR:       if (tmr_done) phase_d = PH_WR_HOLD;
         PH_WR_HOLD: begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(N_TAIL - 1);
            phase_d  = PH_WR_TAIL;
         end
         PH_WR_TAIL:  if (tmr_done) phase_d = PH_IDLE;
         default:     phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         phase_q <= phase_d;
         if (accept) begin
            addr_q  <= addr;
            wdata_q <= wdata;
         end
      end
   end

   assign phase = phase_q;
   assign ready = (phase_q == PH_IDLE);

   // R2: the captured request cannot be disturbed while a transaction runs.
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(addr_q));
   assert_wdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> $stable(wdata_q));

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic              capture,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              cs_n,
   output logic              cs,
   output logic              oe_n,
   output logic              we_n,
   output logic [DATA_W-1:0] rdata
);
   logic selected;

   always_comb begin
      selected = (phase == PH_RD) || (phase == PH_WR) || (phase == PH_WR_HOLD);
      cs_n     = !selected;
      cs       = selected;
      oe_n     = (phase != PH_RD);
      we_n     = (phase != PH_WR);
      dq_oe    = (phase == PH_WR) || (phase == PH_WR_HOLD);
   end

   assign mem_addr = addr_q;
   assign dq_out   = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= dq_in;
   end

   // R3: read sampling happens only inside an output-enable window.
   assert_capture_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (!oe_n && !cs_n && cs));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_RC_NS       = 70,
   parameter int T_AA_NS       = 70,
   parameter int T_ACS_NS      = 70,
   parameter int T_AOE_NS      = 35,
   parameter int T_CHZ_NS      = 30,
   parameter int T_OHZ_NS      = 30,
   parameter int T_WC_NS       = 70,
   parameter int T_WP_NS       = 50,
   parameter int T_CW_NS       = 55,
   parameter int T_AW_NS       = 55,
   parameter int T_DW_NS       = 45
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_oe_n,
   output logic              mem_we_n
);
   localparam int unsigned P = CLK_PERIOD_NS;
   localparam int unsigned N_RD = max_u(max_u(ns_to_cycles(T_RC_NS, P), ns_to_cycles(T_AA_NS, P)),
                                        max_u(ns_to_cycles(T_ACS_NS, P), ns_to_cycles(T_AOE_NS, P)));
   localparam int unsigned N_HZ = max_u(ns_to_cycles(T_CHZ_NS, P), ns_to_cycles(T_OHZ_NS, P));
   localparam int unsigned N_WP = max_u(max_u(ns_to_cycles(T_WP_NS, P), ns_to_cycles(T_CW_NS, P)),
                                        max_u(ns_to_cycles(T_AW_NS, P), ns_to_cycles(T_DW_NS, P)));
   localparam int unsigned N_WC = ns_to_cycles(T_WC_NS, P);
   localparam int unsigned N_TAIL = (N_WC > N_WP + 1) ? (N_WC - N_WP - 1) : 1;
   localparam int unsigned N_MAX = max_u(max_u(N_RD, N_HZ), max_u(N_WP, N_TAIL));
   localparam int CNT_W = $clog2(N_MAX + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("sram_async_ctrl: ADDR_W must lie in 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("sram_async_ctrl: DATA_W must be at least 1");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("sram_async_ctrl: CLK_PERIOD_NS must be at least 1");
      end
   endgenerate

   phase_e             phase;
   logic               capture;
   logic               tmr_load;
   logic               tmr_done;
   logic [CNT_W-1:0]   tmr_val;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_seq_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .N_RD   (int'(N_RD)),
      .N_HZ   (int'(N_HZ)),
      .N_WP   (int'(N_WP)),
      .N_TAIL (int'(N_TAIL))
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (host_req),
      .we       (host_we),
      .addr     (host_addr),
      .wdata    (host_wdata),
      .tmr_done (tmr_done),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .phase    (phase),
      .ready    (host_ready),
      .capture  (capture),
      .addr_q   (addr_q),
      .wdata_q  (wdata_q)
   );

   sram_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .capture  (capture),
      .addr_q   (addr_q),
      .wdata_q  (wdata_q),
      .dq_in    (mem_dq_in),
      .mem_addr (mem_addr),
      .dq_out   (mem_dq_out),
      .dq_oe    (mem_dq_oe),
      .cs_n     (mem_cs_n),
      .cs       (mem_cs),
      .oe_n     (mem_oe_n),
      .we_n     (mem_we_n),
      .rdata    (host_rdata)
   );

   // R1: ready (from the sequencer) implies quiet pins (from the decoder).
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

   // R6: a write strobe never overlaps output enable and always has the chip selected and data driven.
   assert_write_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_cs && mem_dq_oe));

   // R7: bus drive is confined to the strobe plus one trailing cycle.
   assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

   // R4: read data moves only right after an output-enable window.
   assert_rdata_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(host_rdata) |-> $past(!mem_oe_n));

   // R5: leaving a read never hands the bus straight to the controller.
   assert_read_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (!mem_dq_oe && mem_cs_n));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
   localparam int PER  = 8;
   localparam int AW   = 6;
   localparam int DW   = 8;
   localparam int NLOC = 1 << AW;
   // Expected counts straight from the requirement formulas at an 8 ns clock.
   localparam int EXP_RD   = (70 + PER - 1) / PER;                       // 9
   localparam int EXP_HZ   = (30 + PER - 1) / PER;                       // 4
   localparam int EXP_WP   = (55 + PER - 1) / PER;                       // max(50,55,55,45) -> 7
   localparam int EXP_WC   = (70 + PER - 1) / PER;                       // 9
   localparam int EXP_TAIL = (EXP_WC > EXP_WP + 1) ? EXP_WC - EXP_WP - 1 : 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          ready;
   logic [DW-1:0] rdata;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] dq_out;
   logic [DW-1:0] dq_in;
   logic          dq_oe, cs_n, cs, oe_n, we_n;

   always #(PER/2) clk = ~clk;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr),
      .host_wdata(wdata), .host_ready(ready), .host_rdata(rdata), .mem_addr(m_addr),
      .mem_dq_out(dq_out), .mem_dq_in(dq_in), .mem_dq_oe(dq_oe), .mem_cs_n(cs_n),
      .mem_cs(cs), .mem_oe_n(oe_n), .mem_we_n(we_n)
   );

   // ---------------- RAM model with access delay and float time ----------------
   logic [DW-1:0] mem [NLOC];
   int            rd_cnt, hz_cnt, wl_cnt;
   logic [AW-1:0] rd_a, wa;
   logic [DW-1:0] wd;
   int            m_checks = 0, m_errors = 0;
   logic          sel;

   assign sel   = !cs_n && cs;
   assign dq_in = (sel && !oe_n && we_n && rd_cnt >= EXP_RD) ? mem[m_addr] : 8'hEE;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NLOC; i++) mem[i] <= '0;
         rd_cnt <= 0; hz_cnt <= 0; wl_cnt <= 0; rd_a <= '0; wa <= '0; wd <= '0;
      end else begin
         if (sel && !oe_n && we_n) begin
            if (rd_cnt != 0) begin
               m_checks++;
               if (m_addr != rd_a) begin
                  m_errors++;
                  $display("FAIL R3 address moved in read: %0h expected %0h", m_addr, rd_a);
               end
            end
            rd_a   <= m_addr;
            rd_cnt <= rd_cnt + 1;
            hz_cnt <= EXP_HZ;
         end else begin
            rd_cnt <= 0;
            if (hz_cnt > 0) hz_cnt <= hz_cnt - 1;
         end
         m_checks++;
         if (dq_oe && (hz_cnt > 0 || (sel && !oe_n))) begin
            m_errors++;
            $display("FAIL R5 bus contention: dq_oe=%0b hz=%0d expected dq_oe=0", dq_oe, hz_cnt);
         end
         if (sel && !we_n) begin
            m_checks++;
            if (!dq_oe || !oe_n) begin
               m_errors++;
               $display("FAIL R7 strobe without drive: dq_oe=%0b oe_n=%0b expected 1 1", dq_oe, oe_n);
            end
            wl_cnt <= wl_cnt + 1; wd <= dq_out; wa <= m_addr;
         end else if (wl_cnt > 0) begin
            m_checks += 2;
            if (wl_cnt != EXP_WP) begin
               m_errors++;
               $display("FAIL R6 write pulse %0d cycles expected %0d", wl_cnt, EXP_WP);
            end
            if (!(dq_oe && sel && dq_out == wd)) begin
               m_errors++;
               $display("FAIL R7 hold cycle: oe=%0b sel=%0b data=%0h expected 1 1 %0h", dq_oe, sel, dq_out, wd);
            end
            mem[wa] <= wd;
            wl_cnt  <= 0;
         end
         if (ready) begin
            m_checks++;
            if (!(cs_n && !cs && oe_n && we_n && !dq_oe)) begin
               m_errors++;
               $display("FAIL R1 idle pins %b%b%b%b%b expected 10110", cs_n, cs, oe_n, we_n, dq_oe);
            end
         end
      end
   end

   // ---------------- stimulus and checks ----------------
   int            checks = 0, errors = 0;
   logic [DW-1:0] exp_mem [NLOC];

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", rq, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] patt(input int a);
      return DW'((a * 37 + 5) ^ 8'hA5);
   endfunction

   // Called at a negedge; returns at the negedge where ready is back.
   task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int busy);
      req = 1'b1; we = w; addr = a; wdata = d;
      while (!ready) @(negedge clk);
      @(negedge clk);
      req = 1'b0;
      chk(!ready, "R9 accept on first ready cycle", ready, 0);
      busy = 0;
      while (!ready) begin busy++; @(negedge clk); end
   endtask

   initial begin
      int busy;
      for (int i = 0; i < NLOC; i++) exp_mem[i] = '0;
      repeat (5) @(negedge clk);
      chk(ready && cs_n && !cs && oe_n && we_n && !dq_oe && rdata == 0, "R1 reset state",
          {ready, cs_n, cs, oe_n, we_n, dq_oe}, 6'b110110);
      rst_n = 1'b1;
      @(negedge clk);

      // Full write sweep (R6, R7, R8), then full read sweep (R3, R5).
      for (int a = 0; a < NLOC; a++) begin
         run_op(1'b1, AW'(a), patt(a), busy);
         exp_mem[a] = patt(a);
         chk(busy == EXP_WP + 1 + EXP_TAIL, "R8 write occupancy", busy, EXP_WP + 1 + EXP_TAIL);
      end
      for (int a = NLOC - 1; a >= 0; a--) begin
         run_op(1'b0, AW'(a), '0, busy);
         chk(rdata == exp_mem[a], "R3 read data", rdata, exp_mem[a]);
         chk(busy == EXP_RD + EXP_HZ, "R5 read occupancy", busy, EXP_RD + EXP_HZ);
      end

      // Alternating read/write back-to-back on neighbouring addresses.
      for (int a = 0; a < 16; a++) begin
         run_op(1'b0, AW'(a), '0, busy);
         chk(rdata == exp_mem[a], "R3 read before write", rdata, exp_mem[a]);
         run_op(1'b1, AW'(a), ~exp_mem[a], busy);
         exp_mem[a] = ~exp_mem[a];
         chk(rdata == ~exp_mem[a], "R4 rdata kept across write", rdata, ~exp_mem[a]);
      end

      // Request pulsed while busy must be ignored (R2).
      req = 1'b1; we = 1'b1; addr = 6'd3; wdata = 8'h11;
      @(negedge clk);
      req = 1'b0;
      exp_mem[3] = 8'h11;
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 6'd4; wdata = 8'h77;
      @(negedge clk);
      req = 1'b0;
      while (!ready) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         chk(ready && we_n, "R2 no stray transaction", {ready, we_n}, 2'b11);
         @(negedge clk);
      end
      run_op(1'b0, 6'd4, '0, busy);
      chk(rdata == exp_mem[4], "R2 ignored write left location", rdata, exp_mem[4]);
      run_op(1'b0, 6'd3, '0, busy);
      chk(rdata == 8'h11, "R3 accepted write landed", rdata, 8'h11);

      // R4: rdata stable through idle time and a later write.
      repeat (6) @(negedge clk);
      chk(rdata == 8'h11, "R4 rdata held in idle", rdata, 8'h11);
      run_op(1'b1, 6'd5, 8'h5A, busy);
      exp_mem[5] = 8'h5A;
      chk(rdata == 8'h11, "R4 rdata held over write", rdata, 8'h11);
      run_op(1'b0, 6'd5, '0, busy);
      chk(rdata == 8'h5A, "R3 read after write", rdata, 8'h5A);

      $display("CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
      $finish;
   end

   initial begin
      #(PER * 150000);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks + m_checks + 1, errors + m_errors);
      $finish;
   end

endmodule